// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block runs a scan over a multiplexed 16-bit analog-to-digital converter. A 10-bit mask selects channels. Indices 0 to 7 are the external inputs. Index 8 is the 0 V reference and index 9 is the +10 V reference. One start pulse converts every selected channel, lowest index first. Before each conversion the block drives the multiplexer select to the channel and waits a settling time of `SETTLE_CYC` clock cycles. A configuration bit can skip that wait, which makes repeated sampling of one channel faster. The converter itself sits outside the block and is reached through a one-cycle start pulse and a done strobe that carries the result.

Every result is stored in a buffer that belongs to its channel. The host reads any buffer through one shared data output by setting a 4-bit select. When a scan ends, a sticky completion flag is raised. The host clears the flag by writing one to it. The flag can also raise an interrupt, gated by an enable bit.

Top module: `adc_scan_seq`

## Requirements
- R1: Mask bit i selects channel i. During a conversion, `mux_sel` shows the channel index: 0 to 7 for the inputs, 8 for the 0 V reference and 9 for the +10 V reference.
- R2: One start converts each selected channel exactly once, in ascending index order, with one `conv_start` pulse per channel.
- R3: Unless the wait is disabled, `mux_sel` holds the channel for exactly `SETTLE_CYC` cycles before its one-cycle `conv_start` pulse. `mux_sel` stays unchanged until `conv_done` arrives.
- R4: When `cfg_settle_off` is 1 at the start, every channel of that scan gets its `conv_start` in the cycle right after the start, or right after the previous result.
- R5: On `conv_done`, `conv_data` is stored bit for bit in the current channel's buffer. The value is two's complement, 0x7FFF to 0x8000. Buffers of channels that were not selected keep their old values.
- R6: `rd_data` shows the buffer chosen by `cfg_rd_sel` without delay. Select values 10 to 15 read 0.
- R7: `done_flag` rises in the cycle after the last result is accepted. `irq` is `done_flag` AND `cfg_irq_en`.
- R8: A `clr_done` pulse clears `done_flag`. If a completion occurs in the same cycle, the flag stays set.
- R9: A start while `busy` is 1 is ignored. The mask and the settle setting are taken only when a scan begins.
- R10: A start with an all-zero mask sets `done_flag` one cycle later, emits no `conv_start`, and never raises `busy`.
- R11: After reset, `busy`, `done_flag` and `irq` are 0 and every buffer reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mask | input | 10 | Channel select mask (bit i = channel i) |
| cfg_settle_off | input | 1 | 1 skips the settling wait |
| cfg_rd_sel | input | 4 | Buffer select for `rd_data` |
| cfg_irq_en | input | 1 | Interrupt enable |
| start | input | 1 | Start pulse for a scan |
| clr_done | input | 1 | Write-one-to-clear for `done_flag` |
| rd_data | output | 16 | Selected result buffer |
| busy | output | 1 | Scan in progress |
| done_flag | output | 1 | Sticky scan-complete status |
| irq | output | 1 | Interrupt request |
| mux_sel | output | 4 | Multiplexer channel select |
| conv_start | output | 1 | One-cycle converter start |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 16 | Converter result |

## Verification
The bench builds the block with `SETTLE_CYC` = 6 instead of the default of several thousand cycles. This lets it count every settling window exactly and still run many full scans, including scans of all ten channels. The converter model answers four cycles after each start and returns a channel-dependent value. That value can be made 0x7FFF or 0x8000, which tests that both extremes are stored unchanged. Because `DATA_W` stays at 16, the read port and the zero read for select values 10 to 15 are tested at their real width.

// File: rtl/adc_scan_pkg.sv
// Shared constants and types of the ADC scan sequencer.
// Assumes a fixed map: ten channels (eight inputs plus two references).
package adc_scan_pkg;
    localparam int NUM_CH = 10;
    localparam int CH_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_WAIT   = 2'd3
    } scan_state_t;
endpackage

// File: rtl/adc_scan_picker.sv
// Finds the lowest set mask bit whose index is at or above `base`.
// Pure combinational logic. A base of N or above gives found = 0.
module adc_scan_picker #(
    parameter int N = 10,
    parameter int W = 4
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] base,
    output logic         found,
    output logic [W-1:0] idx
);
    // Search downward so that the lowest qualifying index is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(base))) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Scan control: latches the configuration at start and walks the mask.
// Runs the settling counter, pulses the converter start and holds the
// sticky done flag. Assumes conv_done comes only after conv_start.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int SETTLE_CYC = 3750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cfg_mask,
    input  logic              cfg_settle_off,
    input  logic              start,
    input  logic              clr_done,
    input  logic              conv_done,
    output logic              busy,
    output logic [CH_W-1:0]   mux_sel,
    output logic              conv_start,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_idx,
    output logic              done_flag
);
    localparam int  LAST_CNT  = (SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0;
    localparam int  CNT_W     = (LAST_CNT > 0) ? $clog2(LAST_CNT + 1) : 1;
    localparam bit  NO_SETTLE = (SETTLE_CYC == 0);

    scan_state_t       state_q;
    logic [NUM_CH-1:0] mask_q;
    logic              skip_q;
    logic [CH_W-1:0]   cur_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [NUM_CH-1:0] pick_mask;
    logic [CH_W-1:0]   pick_base;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    logic              is_idle;
    logic              finish_evt;

    // Picker input: the live mask from index 0 when idle, else the latched mask above the current channel.
    always_comb begin
        is_idle   = (state_q == ST_IDLE);
        pick_mask = is_idle ? cfg_mask : mask_q;
        pick_base = is_idle ? '0 : cur_q + 1'b1;
    end

    adc_scan_picker #(.N(NUM_CH), .W(CH_W)) picker_i (
        .mask  (pick_mask),
        .base  (pick_base),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Scan end: an empty mask at start, or the last result accepted.
    assign finish_evt = ((is_idle && start) || (state_q == ST_WAIT && conv_done))
                        && !pick_found;

    // Main sequence: idle -> settle -> launch -> wait -> next channel or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            skip_q  <= 1'b0;
            cur_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q <= cfg_mask;
                        skip_q <= cfg_settle_off;
                        if (pick_found) begin
                            cur_q   <= pick_idx;
                            cnt_q   <= '0;
                            state_q <= (cfg_settle_off || NO_SETTLE) ? ST_LAUNCH : ST_SETTLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == CNT_W'(LAST_CNT)) begin
                        state_q <= ST_LAUNCH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_LAUNCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (pick_found) begin
                            cur_q   <= pick_idx;
                            cnt_q   <= '0;
                            state_q <= (skip_q || NO_SETTLE) ? ST_LAUNCH : ST_SETTLE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky done flag: a completion wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (finish_evt) begin
            done_flag <= 1'b1;
        end else if (clr_done) begin
            done_flag <= 1'b0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy       = !is_idle;
        mux_sel    = cur_q;
        conv_start = (state_q == ST_LAUNCH);
        wr_en      = (state_q == ST_WAIT) && conv_done;
        wr_idx     = cur_q;
    end
endmodule

// File: rtl/adc_result_bank.sv
// One result register per channel, with a single combinational read port.
// Select values that name no channel read as zero.
module adc_result_bank #(
    parameter int N      = 10,
    parameter int W      = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [W-1:0]      rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Capture the result addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    // Read mux: a select with no matching slot leaves the output at zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_sel == W'(i)) rd_data = slot_q[i];
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Top of the ADC scan sequencer: scan control, result buffers, interrupt gate.
// Assumes the converter answers each conv_start with one conv_done strobe.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SETTLE_CYC = 3750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        cfg_mask,
    input  logic              cfg_settle_off,
    input  logic [3:0]        cfg_rd_sel,
    input  logic              cfg_irq_en,
    input  logic              start,
    input  logic              clr_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done_flag,
    output logic              irq,
    output logic [3:0]        mux_sel,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data
);
    logic            wr_en;
    logic [CH_W-1:0] wr_idx;

    adc_scan_ctrl #(.SETTLE_CYC(SETTLE_CYC)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_mask       (cfg_mask),
        .cfg_settle_off (cfg_settle_off),
        .start          (start),
        .clr_done       (clr_done),
        .conv_done      (conv_done),
        .busy           (busy),
        .mux_sel        (mux_sel),
        .conv_start     (conv_start),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .done_flag      (done_flag)
    );

    adc_result_bank #(.N(NUM_CH), .W(CH_W), .DATA_W(DATA_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (conv_data),
        .rd_sel  (cfg_rd_sel),
        .rd_data (rd_data)
    );

    // Interrupt: the status flag gated by its enable.
    assign irq = done_flag && cfg_irq_en;
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Port-level properties of the scan sequencer, attached to every instance by bind.
module adc_scan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] cfg_mask,
    input logic       start,
    input logic       clr_done,
    input logic       busy,
    input logic       done_flag,
    input logic       irq,
    input logic [3:0] mux_sel,
    input logic       conv_start,
    input logic       conv_done
);
    AST_MUX_RANGE:      assert property (@(posedge clk) disable iff (!rst_n) busy |-> (mux_sel < 4'd10)); // R1
    AST_START_BEGINS:   assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && cfg_mask != 10'd0) |=> busy); // R2
    AST_PULSE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) conv_start |=> !conv_start); // R3
    AST_MUX_HELD:       assert property (@(posedge clk) disable iff (!rst_n) (busy && !conv_done) |=> $stable(mux_sel)); // R3
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> done_flag); // R7
    AST_CLEAR_WORKS:    assert property (@(posedge clk) disable iff (!rst_n) (clr_done && !busy && !start) |=> !done_flag); // R8
    AST_IDLE_NO_CONV:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !conv_start); // R9
    AST_EMPTY_MASK:     assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && cfg_mask == 10'd0) |=> (done_flag && !busy)); // R10
endmodule

bind adc_scan_seq adc_scan_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mask   (cfg_mask),
    .start      (start),
    .clr_done   (clr_done),
    .busy       (busy),
    .done_flag  (done_flag),
    .irq        (irq),
    .mux_sel    (mux_sel),
    .conv_start (conv_start),
    .conv_done  (conv_done)
);

// File: tb/adc_scan_seq_tb_top.sv
// Directed bench: one task per scenario, with a converter model that logs each conversion.
module adc_scan_seq_tb_top;
    localparam int SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_mask = '0;
    logic        cfg_settle_off = 1'b0;
    logic [3:0]  cfg_rd_sel = '0;
    logic        cfg_irq_en = 1'b0;
    logic        start = 1'b0;
    logic        clr_done = 1'b0;
    logic [15:0] rd_data;
    logic        busy, done_flag, irq, conv_start;
    logic [3:0]  mux_sel;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic        pend = 1'b0;
    int          dly = 0;
    int          st_cnt = 0;
    int          n_conv = 0;
    int          ord [128];
    int          settle_seen [128];
    logic [15:0] salt = '0;

    always #2 clk = ~clk;

    adc_scan_seq #(.DATA_W(16), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_settle_off(cfg_settle_off),
        .cfg_rd_sel(cfg_rd_sel), .cfg_irq_en(cfg_irq_en), .start(start), .clr_done(clr_done),
        .rd_data(rd_data), .busy(busy), .done_flag(done_flag), .irq(irq), .mux_sel(mux_sel),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data)
    );

    // Converter model: logs the channel and settle length, answers four cycles later.
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            pend   <= 1'b0;
            st_cnt <= 0;
        end else if (conv_start) begin
            ord[n_conv]         <= int'(mux_sel);
            settle_seen[n_conv] <= st_cnt;
            n_conv              <= n_conv + 1;
            st_cnt              <= 0;
            pend                <= 1'b1;
            dly                 <= 3;
        end else if (pend) begin
            if (dly == 0) begin
                conv_done <= 1'b1;
                conv_data <= salt + 16'h1111 * {12'd0, mux_sel};
                pend      <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end else if (busy) begin
            st_cnt <= st_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic clear_done();
        @(negedge clk) clr_done = 1'b1;
        @(negedge clk) clr_done = 1'b0;
    endtask

    task automatic run_scan(input logic [9:0] m, input logic off, input logic [15:0] s);
        cfg_mask = m;
        cfg_settle_off = off;
        salt = s;
        pulse_start();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] val(input logic [15:0] s, input int ch);
        return s + 16'h1111 * 16'(ch);
    endfunction

    task automatic t_reset();
        check("R11 busy", busy, 0);
        check("R11 done", done_flag, 0);
        check("R11 irq", irq, 0);
        for (int k = 0; k < 10; k++) begin
            cfg_rd_sel = 4'(k); #1;
            check("R11 buffer", rd_data, 0);
        end
    endtask

    task automatic t_full_scan();
        int b = n_conv;
        cfg_irq_en = 1'b1;
        run_scan(10'h3FF, 1'b0, 16'h0100);
        check("R2 count", n_conv - b, 10);
        for (int k = 0; k < 10; k++) begin
            check("R1 R2 order", ord[b + k], k);
            check("R3 settle", settle_seen[b + k], SETTLE);
            cfg_rd_sel = 4'(k); #1;
            check("R5 R6 buffer", rd_data, val(16'h0100, k));
        end
        check("R7 done", done_flag, 1);
        check("R7 irq", irq, 1);
        cfg_irq_en = 1'b0; #1;
        check("R7 irq gated", irq, 0);
    endtask

    task automatic t_clear();
        clear_done();
        check("R8 cleared", done_flag, 0);
    endtask

    task automatic t_sparse();
        int b = n_conv;
        int exp_ch [4] = '{0, 2, 5, 9};
        run_scan(10'b10_0010_0101, 1'b0, 16'h2000);
        check("R2 sparse count", n_conv - b, 4);
        for (int k = 0; k < 4; k++) check("R2 sparse order", ord[b + k], exp_ch[k]);
        cfg_rd_sel = 4'd1; #1;
        check("R5 unselected kept", rd_data, val(16'h0100, 1));
        cfg_rd_sel = 4'd9; #1;
        check("R5 ref +10V", rd_data, val(16'h2000, 9));
        check("R7 irq off", irq, 0);
        clear_done();
    endtask

    task automatic t_settle_off();
        int b = n_conv;
        run_scan(10'h3FF, 1'b1, 16'h7FFF);
        check("R4 count", n_conv - b, 10);
        for (int k = 0; k < 10; k++) check("R4 no settle", settle_seen[b + k], 0);
        cfg_rd_sel = 4'd0; #1;
        check("R5 max positive", rd_data, 16'h7FFF);
        run_scan(10'h001, 1'b0, 16'h8000);
        cfg_rd_sel = 4'd0; #1;
        check("R5 max negative", rd_data, 16'h8000);
        clear_done();
    endtask

    task automatic t_busy_start();
        int b = n_conv;
        cfg_mask = 10'h003;
        cfg_settle_off = 1'b0;
        salt = 16'h3000;
        pulse_start();
        repeat (3) @(negedge clk);
        cfg_mask = 10'h3FF;
        cfg_settle_off = 1'b1;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R9 count", n_conv - b, 2);
        check("R9 settle kept", settle_seen[b + 1], SETTLE);
        check("R9 idle after", busy, 0);
        clear_done();
    endtask

    task automatic t_zero_mask();
        int b = n_conv;
        cfg_mask = '0;
        @(negedge clk) begin start = 1'b1; clr_done = 1'b1; end
        @(negedge clk) begin start = 1'b0; clr_done = 1'b0; end
        check("R10 R8 done set wins", done_flag, 1);
        check("R10 not busy", busy, 0);
        repeat (10) @(negedge clk);
        check("R10 no conversion", n_conv - b, 0);
        clear_done();
    endtask

    task automatic t_sel_high();
        for (int k = 10; k < 16; k++) begin
            cfg_rd_sel = 4'(k); #1;
            check("R6 high select zero", rd_data, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_scan();
        t_clear();
        t_sparse();
        t_settle_off();
        t_busy_start();
        t_zero_mask();
        t_sel_high();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule